// File: doc/BRIEF.md
# Pointer-Assisted SEC-DED Read Corrector

This block sits on the read path of one protected memory line. It takes the raw data word with its stored check bits. It also takes a local correction entry: a used flag, a bit pointer and the bit's true value. A two-bit hard-error status completes the input. Bit values already known to be stuck are folded into the data with XOR before the single-error-correct, double-error-detect decode. The decoder therefore sees only the errors that nothing has recorded.

The status decides whether a line needs the extra correction entries held in a global store, and when they are fetched. With one recorded hard error, or none, the local entry is enough. With two, the local entry is applied first, and a fetch happens only if the decoder still reports two errors. With more than two, the global entries are always fetched first. The fetch is a valid/ready request that carries the line number. It is answered by a single-cycle response holding up to `G_N` pointer/value pairs, each with its own valid flag. The block returns the corrected word and an uncorrectable flag as a one-cycle result pulse.

Top module: `pacr_read_corrector`

## Requirements
- R1: After reset, `out_valid` and `g_req_valid` are low.
- R2: Check-bit layout: data bit i sits at the i-th codeword position (counting from 1) that is not a power of two. `rd_chk[j]` for j below the parity count is even parity over the data bits whose position has bit j set. The top check bit is even parity over all data bits and all positional check bits.
- R3: With status 00, any single flipped data or check bit is corrected, and the result pulse comes two clock edges after the start edge, with no global request.
- R4: With status 00 and two flipped bits, the read is flagged uncorrectable, with no global request.
- R5: With status 01, the local entry's value is forced into its pointed bit before decoding. A recorded hard error plus one soft error is corrected without a global request, two edges after start.
- R6: With status 10, only the local entry is applied first. If one error remains, it is corrected without any global request, two edges after start.
- R7: With status 10, if two errors remain after the local merge, exactly one global request is made, the returned entries are merged, and the decode is repeated.
- R8: With status 11, exactly one global request is always made. Local and global entries are merged before the only decode.
- R9: A global pair with its valid flag low is ignored. The local entry is ignored when its used flag is low or when the status is 00.
- R10: A read is flagged uncorrectable when the decoder still reports a double error after every available entry has been merged.
- R11: While `g_req_valid` is high and `g_req_ready` is low, the request stays up and `g_req_line` stays stable. The line number is the one given at start.
- R12: `out_valid` is high for exactly one cycle per read.
- R13: A global request is raised only for statuses 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | Start a read; sampled while idle |
| rd_line | input | LINE_W | Line number of the read |
| rd_data | input | DATA_W | Raw data word from the array |
| rd_chk | input | CHK_W | Stored check bits |
| rd_stat | input | 2 | Hard-error status: 00 none, 01 one, 10 two, 11 more |
| loc_used | input | 1 | Local entry holds a correction |
| loc_ptr | input | PTR_W | Local entry bit pointer |
| loc_val | input | 1 | Local entry true bit value |
| g_req_valid | output | 1 | Global fetch request |
| g_req_ready | input | 1 | Global store accepts the request |
| g_req_line | output | LINE_W | Line number being fetched |
| g_rsp_valid | input | 1 | Global response present (one cycle) |
| g_rsp_vld | input | G_N | Per-pair valid flags |
| g_rsp_ptr | input | G_N*PTR_W | Per-pair bit pointers, pair k in bits k*PTR_W upward |
| g_rsp_val | input | G_N | Per-pair true bit values |
| out_valid | output | 1 | Result pulse |
| out_data | output | DATA_W | Corrected data |
| out_unc | output | 1 | Read is uncorrectable |

## Verification
Two functions can be active for the same read: the pointer merge of a recorded hard error, and the decoder's correction of a fresh soft error. The bench provokes this by giving stuck bits at the lines' hard-error positions and then flipping one more data or check bit. It judges the result from the corrected word, and from the number of global requests and the result latency the status and soft-error count call for. A status-10 read with and without that extra flip shows whether the single global fetch comes only when the decoder reports a double error after the local merge.

// File: rtl/pacr_pkg.sv
package pacr_pkg;
   // Number of positional parity bits for a data width (overall bit excluded).
   function automatic int par_bits(input int dw);
      int p;
      p = 2;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   // Codeword position (1-based) of data bit idx: the idx-th non power of two.
   function automatic int data_pos(input int idx);
      int res;
      int cnt;
      int p;
      res = 0;
      cnt = 0;
      p = 2;
      while (res == 0) begin
         p++;
         if ((p & (p - 1)) != 0) begin
            if (cnt == idx) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DEC  = 2'd1,
      ST_REQ  = 2'd2,
      ST_WAIT = 2'd3
   } pacr_state_e;
endpackage

// File: rtl/pacr_merge.sv
module pacr_merge #(
   parameter int DATA_W = 512,
   parameter int PTR_W  = 9,
   parameter int N_ENT  = 1
) (
   input  logic [DATA_W-1:0]      din,
   input  logic [N_ENT-1:0]       ent_vld,
   input  logic [N_ENT*PTR_W-1:0] ent_ptr,
   input  logic [N_ENT-1:0]       ent_val,
   output logic [DATA_W-1:0]      dout
);
   if (N_ENT < 1) begin : g_bad_ent
      $error("pacr_merge: N_ENT must be at least 1");
   end

   logic [DATA_W-1:0] flip;

   // Build an XOR mask that drives each pointed bit to its recorded value.
   always_comb begin
      flip = '0;
      for (int e = 0; e < N_ENT; e++) begin
         if (ent_vld[e] && (32'(ent_ptr[e*PTR_W +: PTR_W]) < DATA_W))
            flip[ent_ptr[e*PTR_W +: PTR_W]] =
               din[ent_ptr[e*PTR_W +: PTR_W]] ^ ent_val[e];
      end
   end

   assign dout = din ^ flip;
endmodule

// File: rtl/pacr_secded_dec.sv
module pacr_secded_dec #(
   parameter int DATA_W = 512,
   localparam int P     = pacr_pkg::par_bits(DATA_W),
   localparam int CHK_W = P + 1,
   localparam int CW_N  = DATA_W + P
) (
   input  logic [DATA_W-1:0] din,
   input  logic [CHK_W-1:0]  chk,
   output logic [DATA_W-1:0] dout,
   output logic              err_one,
   output logic              err_unc
);
   logic [P-1:0]      pos_tab [DATA_W];
   logic [P-1:0]      syn;
   logic              ovr;
   logic [DATA_W-1:0] fix;

   for (genvar i = 0; i < DATA_W; i++) begin : g_pos
      localparam int POS = pacr_pkg::data_pos(i);
      assign pos_tab[i] = POS[P-1:0];
      assign fix[i]     = ovr && (syn == pos_tab[i]);
   end

   always_comb begin
      syn = chk[P-1:0];
      for (int i = 0; i < DATA_W; i++)
         if (din[i]) syn = syn ^ pos_tab[i];
   end

   assign ovr     = ^{din, chk};
   assign err_one = ovr && (32'(syn) <= CW_N);
   assign err_unc = (!ovr && (syn != '0)) || (ovr && (32'(syn) > CW_N));
   assign dout    = din ^ fix;
endmodule

// File: rtl/pacr_read_corrector.sv
module pacr_read_corrector #(
   parameter int DATA_W  = 512,
   parameter int LINE_W  = 23,
   parameter int G_N     = 5,
   localparam int PTR_W  = $clog2(DATA_W),
   localparam int CHK_W  = pacr_pkg::par_bits(DATA_W) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_start,
   input  logic [LINE_W-1:0]    rd_line,
   input  logic [DATA_W-1:0]    rd_data,
   input  logic [CHK_W-1:0]     rd_chk,
   input  logic [1:0]           rd_stat,
   input  logic                 loc_used,
   input  logic [PTR_W-1:0]     loc_ptr,
   input  logic                 loc_val,
   output logic                 g_req_valid,
   input  logic                 g_req_ready,
   output logic [LINE_W-1:0]    g_req_line,
   input  logic                 g_rsp_valid,
   input  logic [G_N-1:0]       g_rsp_vld,
   input  logic [G_N*PTR_W-1:0] g_rsp_ptr,
   input  logic [G_N-1:0]       g_rsp_val,
   output logic                 out_valid,
   output logic [DATA_W-1:0]    out_data,
   output logic                 out_unc
);
   import pacr_pkg::*;

   if (DATA_W < 4) begin : g_bad_width
      $error("pacr_read_corrector: DATA_W must be at least 4");
   end
   if (G_N < 1 || G_N > 16) begin : g_bad_gn
      $error("pacr_read_corrector: G_N out of range");
   end

   pacr_state_e       state;
   logic [DATA_W-1:0] work;
   logic [CHK_W-1:0]  chk_r;
   logic [1:0]        stat_r;
   logic              fetched;
   logic [DATA_W-1:0] loc_merged, glb_merged, dec_data;
   logic              dec_one, dec_unc;
   logic              loc_apply;

   assign loc_apply = loc_used && (rd_stat != 2'b00);

   pacr_merge #(.DATA_W(DATA_W), .PTR_W(PTR_W), .N_ENT(1)) u_loc_merge (
      .din(rd_data), .ent_vld(loc_apply), .ent_ptr(loc_ptr),
      .ent_val(loc_val), .dout(loc_merged));

   pacr_merge #(.DATA_W(DATA_W), .PTR_W(PTR_W), .N_ENT(G_N)) u_glb_merge (
      .din(work), .ent_vld(g_rsp_vld), .ent_ptr(g_rsp_ptr),
      .ent_val(g_rsp_val), .dout(glb_merged));

   pacr_secded_dec #(.DATA_W(DATA_W)) u_dec (
      .din(work), .chk(chk_r), .dout(dec_data),
      .err_one(dec_one), .err_unc(dec_unc));

   assign g_req_valid = (state == ST_REQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         work       <= '0;
         chk_r      <= '0;
         stat_r     <= 2'b00;
         fetched    <= 1'b0;
         g_req_line <= '0;
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_unc    <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         unique case (state)
            ST_IDLE: if (rd_start) begin
               work       <= loc_merged;
               chk_r      <= rd_chk;
               stat_r     <= rd_stat;
               g_req_line <= rd_line;
               fetched    <= 1'b0;
               state      <= (rd_stat == 2'b11) ? ST_REQ : ST_DEC;
            end
            ST_DEC: begin
               if (stat_r == 2'b10 && !fetched && dec_unc) begin
                  state <= ST_REQ;
               end else begin
                  out_valid <= 1'b1;
                  out_data  <= dec_data;
                  out_unc   <= dec_unc;
                  state     <= ST_IDLE;
               end
            end
            ST_REQ: if (g_req_ready) state <= ST_WAIT;
            ST_WAIT: if (g_rsp_valid) begin
               work    <= glb_merged;
               fetched <= 1'b1;
               state   <= ST_DEC;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R11: a stalled request holds its valid and line number.
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      g_req_valid && !g_req_ready |=> g_req_valid && $stable(g_req_line));

   // R12: one result pulse per read.
   a_r12_out_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R13: a fetch only for two or more recorded hard errors.
   a_r13_req_stat: assert property (@(posedge clk) disable iff (!rst_n)
      g_req_valid |-> stat_r[1]);

   // R8: status 11 never finishes without the global entries.
   a_r8_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (stat_r == 2'b11) |-> fetched);

   // R3/R5: statuses 00 and 01 never reach a fetch.
   a_r5_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !stat_r[1] |-> !fetched);
endmodule

// File: tb/pacr_read_corrector_tb.sv
`timescale 1ns/1ps
module pacr_read_corrector_tb_top;
   localparam int DW = 8;
   localparam int LW = 6;
   localparam int GN = 5;
   localparam int PW = 3;
   localparam int CW = 5;

   typedef struct packed {
      logic [7:0] d;
      logic [7:0] hard;
      logic [7:0] sdat;
      logic [4:0] schk;
      logic [1:0] dly;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{8'hA5, 8'h00, 8'h00, 5'h00, 2'd0},  // R3 clean
      '{8'hA5, 8'h00, 8'h04, 5'h00, 2'd0},  // R3 data flip
      '{8'h3C, 8'h00, 8'h00, 5'h04, 2'd0},  // R3 check flip
      '{8'h3C, 8'h00, 8'h00, 5'h10, 2'd0},  // R3 overall bit flip
      '{8'hF0, 8'h00, 8'h81, 5'h00, 2'd0},  // R4 double
      '{8'h5A, 8'h02, 8'h00, 5'h00, 2'd0},  // R5 one hard
      '{8'h5A, 8'h02, 8'h40, 5'h00, 2'd0},  // R5 hard + soft
      '{8'h96, 8'h12, 8'h00, 5'h00, 2'd0},  // R6 two hard
      '{8'h96, 8'h12, 8'h01, 5'h00, 2'd0},  // R7 two hard + soft
      '{8'h96, 8'h12, 8'h00, 5'h02, 2'd1},  // R7 two hard + check flip
      '{8'h0F, 8'h8B, 8'h00, 5'h00, 2'd2},  // R8 four hard, stalled
      '{8'h0F, 8'h8B, 8'h20, 5'h00, 2'd0},  // R8 four hard + soft
      '{8'hC3, 8'h29, 8'h44, 5'h00, 2'd0},  // R10 three hard + double
      '{8'h00, 8'h80, 8'h00, 5'h01, 2'd0},  // R5 hard + check flip
      '{8'hFF, 8'h00, 8'h00, 5'h00, 2'd3}   // R3 all ones
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_start = 1'b0;
   logic [LW-1:0] rd_line = '0;
   logic [DW-1:0] rd_data = '0;
   logic [CW-1:0] rd_chk = '0;
   logic [1:0]    rd_stat = '0;
   logic          loc_used = 1'b0;
   logic [PW-1:0] loc_ptr = '0;
   logic          loc_val = 1'b0;
   logic          g_req_valid;
   logic          g_req_ready = 1'b0;
   logic [LW-1:0] g_req_line;
   logic          g_rsp_valid = 1'b0;
   logic [GN-1:0] g_rsp_vld = '0;
   logic [GN*PW-1:0] g_rsp_ptr = '0;
   logic [GN-1:0] g_rsp_val = '0;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic          out_unc;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   pacr_read_corrector #(.DATA_W(DW), .LINE_W(LW), .G_N(GN)) dut_i (
      .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_line(rd_line),
      .rd_data(rd_data), .rd_chk(rd_chk), .rd_stat(rd_stat),
      .loc_used(loc_used), .loc_ptr(loc_ptr), .loc_val(loc_val),
      .g_req_valid(g_req_valid), .g_req_ready(g_req_ready),
      .g_req_line(g_req_line), .g_rsp_valid(g_rsp_valid),
      .g_rsp_vld(g_rsp_vld), .g_rsp_ptr(g_rsp_ptr), .g_rsp_val(g_rsp_val),
      .out_valid(out_valid), .out_data(out_data), .out_unc(out_unc));

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R2 encoding, written from the requirement.
   function automatic logic [4:0] enc(input logic [7:0] d);
      logic [4:0] c;
      int k;
      c = '0;
      k = 0;
      for (int pos = 1; pos <= 12; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            if (d[k])
               for (int j = 0; j < 4; j++) if (pos[j]) c[j] = ~c[j];
            k++;
         end
      end
      c[4] = ^{d, c[3:0]};
      return c;
   endfunction

   // Global entries prepared for the next response.
   logic [GN-1:0]    nx_vld;
   logic [GN*PW-1:0] nx_ptr;
   logic [GN-1:0]    nx_val;

   task automatic do_read(input int line, input logic [7:0] raw,
                          input logic [4:0] chk, input logic [1:0] stat,
                          input logic lu, input logic [2:0] lp,
                          input logic lv, input int dly,
                          output logic [7:0] dat, output logic unc,
                          output int fetches, output int lat);
      int phase;
      int wcnt;
      bit got;
      phase = 0;
      wcnt = 0;
      got = 0;
      fetches = 0;
      lat = 0;
      dat = '0;
      unc = 1'b0;
      @(negedge clk);
      rd_line = LW'(line);
      rd_data = raw;
      rd_chk = chk;
      rd_stat = stat;
      loc_used = lu;
      loc_ptr = lp;
      loc_val = lv;
      rd_start = 1'b1;
      for (int cyc = 1; cyc <= 40 && !got; cyc++) begin
         @(negedge clk);
         rd_start = 1'b0;
         if (out_valid) begin
            got = 1;
            dat = out_data;
            unc = out_unc;
            lat = cyc;
         end
         if (phase == 3) begin
            g_rsp_valid = 1'b0;
            phase = 0;
         end else if (phase == 2) begin
            g_req_ready = 1'b0;
            g_rsp_valid = 1'b1;
            g_rsp_vld = nx_vld;
            g_rsp_ptr = nx_ptr;
            g_rsp_val = nx_val;
            phase = 3;
         end else if (g_req_valid) begin
            check("R11 request line", 32'(g_req_line), 32'(line));
            if (wcnt >= dly) begin
               g_req_ready = 1'b1;
               fetches++;
               phase = 2;
            end else begin
               wcnt++;
            end
         end
      end
      g_req_ready = 1'b0;
      g_rsp_valid = 1'b0;
      if (!got) check("watchdog result", 0, 1);
   endtask

   initial begin
      #(20ns * 150000);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] dat;
      logic unc;
      int fetches;
      int lat;

      repeat (3) @(negedge clk);
      check("R1 out_valid reset", 32'(out_valid), 0);
      check("R1 g_req_valid reset", 32'(g_req_valid), 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         vec_t t;
         int nh;
         int nsoft;
         int lp;
         int slot;
         int spare;
         logic [1:0] stat;
         bit exp_fetch;
         bit exp_unc;
         t = VEC[v];
         nh = $countones(t.hard);
         nsoft = $countones(t.sdat) + $countones(t.schk);
         stat = (nh >= 3) ? 2'b11 : 2'(nh);
         lp = 0;
         spare = 0;
         for (int b = 7; b >= 0; b--) begin
            if (t.hard[b]) lp = b;
            else spare = b;
         end
         nx_vld = '0;
         nx_ptr = '0;
         nx_val = '0;
         slot = 0;
         for (int b = 0; b < 8; b++) begin
            if (t.hard[b] && b != lp) begin
               nx_vld[slot] = 1'b1;
               nx_ptr[slot*PW +: PW] = 3'(b);
               nx_val[slot] = t.d[b];
               slot++;
            end
         end
         // R9: unused pairs carry a wrong value at a good bit, valid low.
         for (int s = slot; s < GN; s++) begin
            nx_ptr[s*PW +: PW] = 3'(spare);
            nx_val[s] = ~t.d[spare];
         end
         exp_fetch = (stat == 2'b11) || (stat == 2'b10 && nsoft > 0);
         exp_unc = (nsoft >= 2);
         do_read(v, t.d ^ t.hard ^ t.sdat, enc(t.d) ^ t.schk, stat,
                 nh > 0, 3'(lp), t.d[lp], int'(t.dly),
                 dat, unc, fetches, lat);
         check($sformatf("R10 uncorrectable flag vec%0d", v),
               32'(unc), 32'(exp_unc));
         if (!exp_unc)
            check($sformatf("R5 R7 R8 corrected data vec%0d", v),
                  32'(dat), 32'(t.d));
         check($sformatf("R6 R7 R8 fetch count vec%0d", v),
               32'(fetches), exp_fetch ? 1 : 0);
         if (!exp_fetch)
            check($sformatf("R3 R6 latency vec%0d", v), 32'(lat), 2);
         // R12: the pulse has dropped by the next cycle.
         @(negedge clk);
         check("R12 single pulse", 32'(out_valid), 0);
      end

      // R9: local entry with used flag low is ignored (status 01).
      do_read(20, 8'hA5 ^ 8'h08, enc(8'hA5), 2'b01, 1'b0, 3'd0, 1'b0, 0,
              dat, unc, fetches, lat);
      check("R9 unused local entry data", 32'(dat), 32'hA5);
      check("R9 unused local entry flag", 32'(unc), 0);

      // R9: local entry ignored for status 00 even when marked used.
      do_read(21, 8'h3C ^ 8'h40, enc(8'h3C), 2'b00, 1'b1, 3'd0, 1'b1, 0,
              dat, unc, fetches, lat);
      check("R9 status 00 ignores local data", 32'(dat), 32'h3C);
      check("R13 status 00 no fetch", 32'(fetches), 0);

      // R4: double flip confined to check bits.
      do_read(22, 8'h81, enc(8'h81) ^ 5'h05, 2'b00, 1'b0, 3'd0, 1'b0, 0,
              dat, unc, fetches, lat);
      check("R4 double check-bit flip", 32'(unc), 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule